// File: doc/BRIEF.md
# Event Status and Decrementer Unit

This block holds the event state of a processing core and exposes it as a small set of word-wide channels. Event sources elsewhere in the core raise one-cycle pulses that latch into an event-status register. A companion event-mask register selects which latched events software may see. Software reads the status channel to get the latched events ANDed with the mask, and clears events by writing ones to an acknowledge channel. A count flag and an interrupt-request hint follow the masked status.

A 32-bit decrementer sits alongside the status register. Writing it loads a value and restarts the countdown. Each cycle of a timebase enable lowers it by one, and reading it returns the current count. The decrementer drives its own timer event. That event is asserted while the loaded value was zero, or while the running count has its top bit set. A pulse from the reservation tracker sets the reservation-lost event. A separate interrupt-enable flag is written on its own channel and reported on the machine-status read.

Write channel select on `ch_wr_sel_i`: 0 event mask, 1 acknowledge, 2 decrementer load, 3 interrupt enable. Read channel select on `ch_rd_sel_i`: 0 masked status, 1 event mask, 2 decrementer, 3 machine status.

Top module: `evt_unit`

## Requirements
- R1: After synchronous reset the mask, the status register, the interrupt enable and the decrementer are zero, and `ch_rd_data_o`, `evt_cnt_o` and `irq_req_o` are 0.
- R2: A read strobe on channel 0 returns status AND mask on `ch_rd_data_o` one cycle after the strobe, computed from the state before that edge.
- R3: `evt_cnt_o` is 1 exactly when status AND mask is nonzero, and it tracks the state registers with no extra lag.
- R4: A write on channel 1 clears each status bit whose bit in the written word is 1, and leaves the other status bits unchanged.
- R5: The implemented event set is the mask 0x0000052F. A mask write or acknowledge write with any bit set outside it is ignored and leaves the mask and the status unchanged.
- R6: A write on channel 2 loads the decrementer with the written word, and a load in the same cycle as a timebase enable takes priority over the count.
- R7: Each cycle with `tb_tick_i` high and no load lowers the decrementer by one, wrapping modulo 2^32. A read on channel 2 returns the current count.
- R8: Status bit 5 (timer) is set on every edge at which the last loaded value was zero or the decrementer has bit 31 set. Reset counts as a load of zero.
- R9: `rsv_lost_i` sets status bit 10. A pulse on `evt_set_i` sets the status bits it marks within the implemented set, and bits outside that set are ignored.
- R10: When a set source and an acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R11: A write on channel 3 stores bit 0 of the word as the interrupt enable. A read on channel 3 returns it in bit 0, with all other bits zero. `irq_req_o` is the interrupt enable ANDed with `evt_cnt_o`.
- R12: A read on channel 1 returns the current event mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set_i | input | 32 | One-cycle event set pulses, one bit per event |
| rsv_lost_i | input | 1 | Reservation-lost pulse |
| tb_tick_i | input | 1 | Timebase enable; decrementer counts once per high cycle |
| ch_wr_i | input | 1 | Channel write strobe |
| ch_wr_sel_i | input | 2 | Write channel select |
| ch_wr_data_i | input | 32 | Channel write data |
| ch_rd_i | input | 1 | Channel read strobe |
| ch_rd_sel_i | input | 2 | Read channel select |
| ch_rd_data_o | output | 32 | Registered read data |
| evt_cnt_o | output | 1 | Masked status is nonzero |
| irq_req_o | output | 1 | Interrupt enable AND masked status nonzero |

## Verification
A wrong status or mask bit appears on `evt_cnt_o` and `irq_req_o` in the cycle after the edge that corrupts it. It also appears on the next status or mask read. A decrementer that drops or gains a tick shows as a wrong value on the first channel 2 read. If the error pushes bit 31 the wrong way, the timer bit also appears or goes missing one edge later. The bench model is compared on every clock, so a diverging state is reported within one read of the channel that exposes it. Directed sequences cover the corners: a load racing a tick, acknowledge against a set, and rejected writes.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int CH_W = 2;

  typedef enum logic [CH_W-1:0] {
    WR_MASK = 2'd0,
    WR_ACK  = 2'd1,
    WR_DEC  = 2'd2,
    WR_IEN  = 2'd3
  } wr_ch_e;

  typedef enum logic [CH_W-1:0] {
    RD_STAT = 2'd0,
    RD_MASK = 2'd1,
    RD_DEC  = 2'd2,
    RD_MACH = 2'd3
  } rd_ch_e;
endpackage

// File: rtl/evt_decr.sv
module evt_decr #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic          tick_i,
  output logic [DW-1:0] cnt_o,
  output logic          expired_o
);
  logic [DW-1:0] cnt_q;
  logic          zero_ld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      zero_ld_q <= 1'b1;
    end else if (ld_i) begin
      cnt_q     <= ld_val_i;
      zero_ld_q <= (ld_val_i == '0);
    end else if (tick_i) begin
      cnt_q     <= cnt_q - 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = zero_ld_q | cnt_q[DW-1];

  // R6
  load_val_chk: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> cnt_q == $past(ld_val_i));

  // R7
  tick_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !ld_i) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int            DW     = 32,
  parameter logic [DW-1:0] IMPL   = 32'h0000_052F,
  parameter int            TM_BIT = 5,
  parameter int            LR_BIT = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_i,
  input  logic          tm_i,
  input  logic          lr_i,
  input  logic          mask_we_i,
  input  logic          ack_we_i,
  input  logic          ien_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic          ien_o,
  output logic          cnt_o,
  output logic          irq_o
);
  localparam logic [DW-1:0] TM_V = DW'(1) << TM_BIT;
  localparam logic [DW-1:0] LR_V = DW'(1) << LR_BIT;

  logic [DW-1:0] stat_q, stat_n, mask_q, mask_n, set_v;
  logic          ien_q, ien_n, cnt_q, irq_q, cnt_n;
  logic          wd_legal, ack_ok, mask_ok;

  assign wd_legal = ((wdata_i & ~IMPL) == '0);
  assign ack_ok   = ack_we_i  && wd_legal;
  assign mask_ok  = mask_we_i && wd_legal;

  assign set_v = (set_i | (tm_i ? TM_V : '0) | (lr_i ? LR_V : '0)) & IMPL;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      assign stat_n[i] = set_v[i] | (stat_q[i] & ~(ack_ok & wdata_i[i]));
      assign mask_n[i] = mask_ok ? wdata_i[i] : mask_q[i];
    end else begin : g_none
      assign stat_n[i] = 1'b0;
      assign mask_n[i] = 1'b0;
    end
  end

  assign ien_n = ien_we_i ? wdata_i[0] : ien_q;
  assign cnt_n = |(stat_n & mask_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      ien_q  <= 1'b0;
      cnt_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      mask_q <= mask_n;
      ien_q  <= ien_n;
      cnt_q  <= cnt_n;
      irq_q  <= cnt_n & ien_n;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign ien_o  = ien_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;

  // R5
  mask_rej_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_we_i && !wd_legal) |=> $stable(mask_q));

  // R9
  lr_set_chk: assert property (@(posedge clk) disable iff (rst)
    lr_i |=> stat_q[LR_BIT]);

  // R4
  ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_ok && wdata_i[LR_BIT] && !lr_i && !set_i[LR_BIT]) |=> !stat_q[LR_BIT]);

  // R3
  cnt_match_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q == |(stat_q & mask_q));
endmodule

// File: rtl/evt_rdmux.sv
module evt_rdmux
  import evt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_i,
  input  rd_ch_e        rd_sel_i,
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] dec_i,
  input  logic          ien_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] rd_q, rd_n;

  always_comb begin
    unique case (rd_sel_i)
      RD_STAT: rd_n = stat_i & mask_i;
      RD_MASK: rd_n = mask_i;
      RD_DEC:  rd_n = dec_i;
      RD_MACH: rd_n = {{(DW-1){1'b0}}, ien_i};
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rd_q <= '0;
    else if (rd_i) rd_q <= rd_n;
  end

  assign rd_data_o = rd_q;

  // R11
  mach_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && rd_sel_i == RD_MACH) |=> rd_q[DW-1:1] == '0);

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rd_q));
endmodule

// File: rtl/evt_unit.sv
module evt_unit
  import evt_pkg::*;
#(
  parameter int            DW        = 32,
  parameter logic [DW-1:0] IMPL_MASK = 32'h0000_052F,
  parameter int            TM_BIT    = 5,
  parameter int            LR_BIT    = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   evt_set_i,
  input  logic            rsv_lost_i,
  input  logic            tb_tick_i,
  input  logic            ch_wr_i,
  input  logic [CH_W-1:0] ch_wr_sel_i,
  input  logic [DW-1:0]   ch_wr_data_i,
  input  logic            ch_rd_i,
  input  logic [CH_W-1:0] ch_rd_sel_i,
  output logic [DW-1:0]   ch_rd_data_o,
  output logic            evt_cnt_o,
  output logic            irq_req_o
);
  wr_ch_e        wsel;
  logic          mask_we, ack_we, dec_we, ien_we;
  logic [DW-1:0] dec_cnt, stat, mask;
  logic          expired, ien;

  assign wsel    = wr_ch_e'(ch_wr_sel_i);
  assign mask_we = ch_wr_i && (wsel == WR_MASK);
  assign ack_we  = ch_wr_i && (wsel == WR_ACK);
  assign dec_we  = ch_wr_i && (wsel == WR_DEC);
  assign ien_we  = ch_wr_i && (wsel == WR_IEN);

  evt_decr #(.DW(DW)) i_decr (
    .clk       (clk),
    .rst       (rst),
    .ld_i      (dec_we),
    .ld_val_i  (ch_wr_data_i),
    .tick_i    (tb_tick_i),
    .cnt_o     (dec_cnt),
    .expired_o (expired)
  );

  evt_status #(
    .DW(DW), .IMPL(IMPL_MASK), .TM_BIT(TM_BIT), .LR_BIT(LR_BIT)
  ) i_status (
    .clk       (clk),
    .rst       (rst),
    .set_i     (evt_set_i),
    .tm_i      (expired),
    .lr_i      (rsv_lost_i),
    .mask_we_i (mask_we),
    .ack_we_i  (ack_we),
    .ien_we_i  (ien_we),
    .wdata_i   (ch_wr_data_i),
    .stat_o    (stat),
    .mask_o    (mask),
    .ien_o     (ien),
    .cnt_o     (evt_cnt_o),
    .irq_o     (irq_req_o)
  );

  evt_rdmux #(.DW(DW)) i_rdmux (
    .clk       (clk),
    .rst       (rst),
    .rd_i      (ch_rd_i),
    .rd_sel_i  (rd_ch_e'(ch_rd_sel_i)),
    .stat_i    (stat),
    .mask_i    (mask),
    .dec_i     (dec_cnt),
    .ien_i     (ien),
    .rd_data_o (ch_rd_data_o)
  );

  // R8
  tm_set_chk: assert property (@(posedge clk) disable iff (rst)
    expired |=> stat[TM_BIT]);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> (ien && evt_cnt_o));
endmodule

// File: tb/test_evt_unit.sv
module test_evt_unit;
  localparam logic [31:0] IMPL = 32'h0000_052F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_set = '0;
  logic        rsv = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]  wsel = '0, rsel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cnt, irq;

  int nchk = 0, nfail = 0;
  bit run_cmp = 0, done = 0;
  string tag = "R1";

  always #2ns clk = ~clk;

  evt_unit i_evt_unit (
    .clk(clk), .rst(rst), .evt_set_i(evt_set), .rsv_lost_i(rsv),
    .tb_tick_i(tick), .ch_wr_i(wr), .ch_wr_sel_i(wsel),
    .ch_wr_data_i(wdata), .ch_rd_i(rd), .ch_rd_sel_i(rsel),
    .ch_rd_data_o(rdata), .evt_cnt_o(cnt), .irq_req_o(irq)
  );

  // reference model
  logic [31:0] m_stat, m_mask, m_dec, m_rd;
  logic        m_ien, m_zl, m_cnt, m_irq;

  always @(posedge clk) begin
    logic [31:0] setv, nstat, nmask;
    logic        legal;
    if (rst) begin
      m_stat = 0; m_mask = 0; m_dec = 0; m_rd = 0;
      m_ien = 0; m_zl = 1; m_cnt = 0; m_irq = 0;
    end else begin
      if (rd) begin
        case (rsel)
          2'd0: m_rd = m_stat & m_mask;
          2'd1: m_rd = m_mask;
          2'd2: m_rd = m_dec;
          default: m_rd = {31'd0, m_ien};
        endcase
      end
      legal = ((wdata & ~IMPL) == 0);
      setv  = evt_set | (rsv ? 32'h400 : 0) | ((m_zl || m_dec[31]) ? 32'h20 : 0);
      setv  = setv & IMPL;
      nstat = m_stat;
      if (wr && wsel == 2'd1 && legal) nstat = nstat & ~wdata;
      nstat = (nstat | setv) & IMPL;
      nmask = m_mask;
      if (wr && wsel == 2'd0 && legal) nmask = wdata;
      if (wr && wsel == 2'd3) m_ien = wdata[0];
      if (wr && wsel == 2'd2) begin
        m_dec = wdata; m_zl = (wdata == 0);
      end else if (tick) m_dec = m_dec - 1;
      m_stat = nstat; m_mask = nmask;
      m_cnt = ((m_stat & m_mask) != 0);
      m_irq = m_cnt & m_ien;
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  always @(negedge clk) if (run_cmp) begin
    chk({tag, " R2 rd_data"}, rdata, m_rd);
    chk({tag, " R3 cnt"}, {31'd0, cnt}, {31'd0, m_cnt});
    chk({tag, " R11 irq"}, {31'd0, irq}, {31'd0, m_irq});
  end

  task automatic wr_ch(logic [1:0] s, logic [31:0] d);
    @(negedge clk); wr = 1; wsel = s; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_ch(logic [1:0] s, output logic [31:0] v);
    @(negedge clk); rd = 1; rsel = s;
    @(negedge clk); rd = 0; v = rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    run_cmp = 1;
    // R1
    tag = "R1";
    chk("R1 cnt after reset", {31'd0, cnt}, 0);
    chk("R1 rd_data after reset", rdata, 0);
    rd_ch(2'd3, v); chk("R1 ien reset", v, 0);
    rd_ch(2'd2, v); chk("R1 dec reset", v, 0);
    // R12
    tag = "R12";
    wr_ch(2'd0, 32'h20);
    rd_ch(2'd1, v); chk("R12 mask read", v, 32'h20);
    // R8 zero-load timer
    tag = "R8";
    rd_ch(2'd0, v); chk("R8 timer after zero load", v, 32'h20);
    chk("R3 cnt set", {31'd0, cnt}, 1);
    // R10 level timer survives ack
    tag = "R10";
    wr_ch(2'd1, 32'h20);
    rd_ch(2'd0, v); chk("R10 timer re-set over ack", v, 32'h20);
    // R6/R4
    tag = "R6";
    wr_ch(2'd2, 32'd100);
    wr_ch(2'd1, 32'h20);
    rd_ch(2'd0, v); chk("R4 ack clears timer", v, 0);
    chk("R3 cnt clear", {31'd0, cnt}, 0);
    // R7
    tag = "R7";
    for (int k = 0; k < 10; k++) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
    rd_ch(2'd2, v); chk("R7 dec after 10 ticks", v, 32'd90);
    // R6 load beats tick
    tag = "R6";
    @(negedge clk); wr = 1; wsel = 2'd2; wdata = 32'd5; tick = 1;
    @(negedge clk); wr = 0; tick = 0;
    rd_ch(2'd2, v); chk("R6 load wins over tick", v, 32'd5);
    // R8 negative
    tag = "R8";
    wr_ch(2'd2, 32'd2);
    wr_ch(2'd1, 32'h20);
    for (int k = 0; k < 3; k++) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
    rd_ch(2'd2, v); chk("R7 dec wraps", v, 32'hFFFF_FFFF);
    rd_ch(2'd0, v); chk("R8 timer on bit31", v, 32'h20);
    // R9
    tag = "R9";
    wr_ch(2'd0, IMPL);
    @(negedge clk); rsv = 1;
    @(negedge clk); rsv = 0;
    rd_ch(2'd0, v); chk("R9 reservation lost bit", v & 32'h400, 32'h400);
    @(negedge clk); evt_set = 32'hFFFF_FFFF;
    @(negedge clk); evt_set = 0;
    rd_ch(2'd0, v); chk("R9 set pulses within impl", v, IMPL);
    // R5
    tag = "R5";
    wr_ch(2'd1, 32'h0000_0C00);
    rd_ch(2'd0, v); chk("R5 bad ack ignored", v, IMPL);
    wr_ch(2'd0, 32'h0001_0020);
    rd_ch(2'd1, v); chk("R5 bad mask ignored", v, IMPL);
    // R4
    tag = "R4";
    wr_ch(2'd1, 32'h0000_000F);
    rd_ch(2'd0, v); chk("R4 ack clears ones", v, 32'h520);
    // R10
    tag = "R10";
    @(negedge clk); wr = 1; wsel = 2'd1; wdata = 32'h400; rsv = 1;
    @(negedge clk); wr = 0; rsv = 0;
    rd_ch(2'd0, v); chk("R10 set beats ack", v, 32'h520);
    wr_ch(2'd1, 32'h400);
    rd_ch(2'd0, v); chk("R4 ack clears lost bit", v, 32'h120);
    // R11
    tag = "R11";
    wr_ch(2'd3, 32'hFFFF_FFFF);
    rd_ch(2'd3, v); chk("R11 machine status", v, 32'h1);
    chk("R11 irq raised", {31'd0, irq}, 1);
    wr_ch(2'd3, 32'h0);
    chk("R11 irq dropped", {31'd0, irq}, 0);
    // random traffic against the model
    tag = "R2/R6/R7/R9 random";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      evt_set = ($urandom % 8 == 0) ? ($urandom & 32'hFFF) : 0;
      rsv   = ($urandom % 10 == 0);
      tick  = $urandom % 2;
      wr    = ($urandom % 4 == 0);
      wsel  = 2'($urandom % 4);
      wdata = (wsel == 2'd2) ? (($urandom % 3 == 0) ? 32'($urandom % 4) : $urandom)
                             : (($urandom % 5 == 0) ? $urandom : ($urandom & IMPL));
      rd    = $urandom % 2;
      rsel  = 2'($urandom % 4);
    end
    @(negedge clk);
    evt_set = 0; rsv = 0; tick = 0; wr = 0; rd = 0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule